// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block steps the control pins of an on-chip PLL through a safe frequency change. A rate request carries new feedback (M), pre-divider (P), post-divider (S) and fraction (K) values. The block compares the new M and P with the values the PLL is running on. If both match, only S and K are rewritten and the request completes in one cycle, with no disturbance to the PLL. If either differs, the block does a full relock. It points the lock indication at the PLL output lock, puts the PLL into reset and bypass, and loads the dividers. It then holds reset for a minimum settle time and releases it. It waits a bounded time for lock and leaves bypass only once lock has been seen.

The block also powers the PLL up and down. A power-up request sets bypass, releases reset, waits for lock and then drops bypass. A power-up request does nothing if the PLL is already out of reset. A power-down request pulls reset low. All delays are counted in cycles of a free-running microsecond tick. Each operation ends with a one-cycle done or timeout pulse.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, pll_rstn_o, bypass_o, lock_sel_o, busy_o, done_o, timeout_o and prepared_o are 0, and m_o, p_o, s_o and k_o are 0.
- R2: A rate request accepted while idle with m_i equal to m_o and p_i equal to p_o loads s_i and k_i into s_o and k_o on the next clock edge. On that same edge it pulses done_o. busy_o stays 0 and pll_rstn_o and bypass_o do not change.
- R3: A rate request accepted while idle whose M or P differs from the current values starts a full change. Each step takes one clock edge, in this order: lock_sel_o goes to 1 (when LOCK_SEL_EN is 1), then pll_rstn_o goes to 0, then bypass_o goes to 1, then m_o, p_o, s_o and k_o take the new values.
- R4: After the dividers are loaded, pll_rstn_o stays 0 until more than SETTLE_US microsecond ticks have been seen.
- R5: After reset is released, lock_i at 1 clears bypass_o and pulses done_o on the same edge. bypass_o never falls without lock_i having been 1 on the edge before.
- R6: If lock_i stays 0 for LOCK_TMO_US ticks after reset release, timeout_o pulses and bypass_o and pll_rstn_o both stay 1.
- R7: A power-up request while pll_rstn_o is 1 pulses done_o and changes no control output.
- R8: A power-up request while pll_rstn_o is 0 sets bypass_o. On the following edge it sets pll_rstn_o. The block then waits for lock as in R5 and R6.
- R9: A power-down request accepted while idle drives pll_rstn_o to 0 and pulses done_o on the next edge. bypass_o is left unchanged.
- R10: prepared_o always equals pll_rstn_o.
- R11: busy_o is 1 from the edge that starts a full change or a power-up until the done or timeout pulse. Every request input is ignored while busy_o is 1. When idle, power-down wins over power-up, and power-up wins over a rate request.
- R12: done_o and timeout_o are never 1 together. Each operation produces exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| us_tick_i | input | 1 | One-cycle pulse once per microsecond |
| req_i | input | 1 | Rate change request |
| m_i | input | M_W | Requested feedback divider |
| p_i | input | P_W | Requested pre-divider |
| s_i | input | S_W | Requested post-divider shift |
| k_i | input | K_W | Requested fraction |
| prep_i | input | 1 | Power-up request |
| unprep_i | input | 1 | Power-down request |
| lock_i | input | 1 | Lock status from the PLL |
| pll_rstn_o | output | 1 | PLL reset, active low (0 = powered down) |
| bypass_o | output | 1 | PLL bypass |
| lock_sel_o | output | 1 | Selects the PLL output lock as the lock source |
| m_o | output | M_W | Feedback divider to PLL |
| p_o | output | P_W | Pre-divider to PLL |
| s_o | output | S_W | Post-divider shift to PLL |
| k_o | output | K_W | Fraction to PLL |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: operation finished |
| timeout_o | output | 1 | One-cycle pulse: lock not reached in time |
| prepared_o | output | 1 | Mirrors pll_rstn_o |

## Verification
The bench builds the block with SETTLE_US of 3 and LOCK_TMO_US of 40, and sends a tick every fourth clock. This brings the lock timeout within about 160 cycles and lets the tick count between divider load and reset release be measured exactly. Divider widths and LOCK_SEL_EN keep their defaults, so the lock-select step and 10/6/3/16-bit fields are exercised as in normal use. A behavioral lock model that can be disabled makes both the lock path and the timeout path reachable from power-up.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_BYP,
    ST_LOAD,
    ST_SETTLE,
    ST_PREL,
    ST_LOCK
  } seq_state_e;
endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int CNT_W       = 14,
  parameter int SETTLE_US   = 3,
  parameter int LOCK_TMO_US = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  input  logic en_i,
  output logic settle_ok_o,
  output logic tmo_hit_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cnt_q <= '0;
    else if (clr_i)                             cnt_q <= '0;
    else if (en_i && tick_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign settle_ok_o = cnt_q > CNT_W'(SETTLE_US);
  assign tmo_hit_o   = cnt_q >= CNT_W'(LOCK_TMO_US);
endmodule

// File: rtl/pll_seq_divreg.sv
module pll_seq_divreg #(
  parameter int M_W = 10,
  parameter int P_W = 6,
  parameter int S_W = 3,
  parameter int K_W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [M_W-1:0] m_i,
  input  logic [P_W-1:0] p_i,
  input  logic [S_W-1:0] s_i,
  input  logic [K_W-1:0] k_i,
  input  logic           cap_i,
  input  logic           ld_full_i,
  input  logic           ld_fast_i,
  output logic [M_W-1:0] m_o,
  output logic [P_W-1:0] p_o,
  output logic [S_W-1:0] s_o,
  output logic [K_W-1:0] k_o,
  output logic           mp_match_o
);
  logic [M_W-1:0] pm_q;
  logic [P_W-1:0] pp_q;
  logic [S_W-1:0] ps_q;
  logic [K_W-1:0] pk_q;

  // pending set, held while the PLL is taken down
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pm_q <= '0; pp_q <= '0; ps_q <= '0; pk_q <= '0;
    end else if (cap_i) begin
      pm_q <= m_i; pp_q <= p_i; ps_q <= s_i; pk_q <= k_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_o <= '0; p_o <= '0; s_o <= '0; k_o <= '0;
    end else if (ld_full_i) begin
      m_o <= pm_q; p_o <= pp_q; s_o <= ps_q; k_o <= pk_q;
    end else if (ld_fast_i) begin
      s_o <= s_i; k_o <= k_i;
    end
  end

  assign mp_match_o = (m_i == m_o) && (p_i == p_o);
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter bit LOCK_SEL_EN = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic prep_i,
  input  logic unprep_i,
  input  logic lock_i,
  input  logic mp_match_i,
  input  logic settle_ok_i,
  input  logic tmo_hit_i,
  output logic rstn_o,
  output logic bypass_o,
  output logic lock_sel_o,
  output logic busy_o,
  output logic done_o,
  output logic timeout_o,
  output logic cap_o,
  output logic ld_full_o,
  output logic ld_fast_o,
  output logic tmr_clr_o,
  output logic tmr_en_o
);
  seq_state_e state_q;
  logic       idle, take_req;

  assign idle      = state_q == ST_IDLE;
  assign take_req  = idle && req_i && !unprep_i && !prep_i;
  assign ld_fast_o = take_req && mp_match_i;
  assign cap_o     = take_req && !mp_match_i;
  assign ld_full_o = state_q == ST_LOAD;
  assign tmr_clr_o = ld_full_o || state_q == ST_PREL || (state_q == ST_SETTLE && settle_ok_i);
  assign tmr_en_o  = state_q == ST_SETTLE || state_q == ST_LOCK;
  assign busy_o    = !idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      rstn_o     <= 1'b0;
      bypass_o   <= 1'b0;
      lock_sel_o <= 1'b0;
      done_o     <= 1'b0;
      timeout_o  <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (unprep_i) begin
            rstn_o <= 1'b0;
            done_o <= 1'b1;
          end else if (prep_i) begin
            if (rstn_o) done_o <= 1'b1;
            else begin
              bypass_o <= 1'b1;
              state_q  <= ST_PREL;
            end
          end else if (req_i) begin
            if (mp_match_i) done_o <= 1'b1;
            else begin
              if (LOCK_SEL_EN) lock_sel_o <= 1'b1;
              state_q <= ST_RST;
            end
          end
        end
        ST_RST: begin
          rstn_o  <= 1'b0;
          state_q <= ST_BYP;
        end
        ST_BYP: begin
          bypass_o <= 1'b1;
          state_q  <= ST_LOAD;
        end
        ST_LOAD: state_q <= ST_SETTLE;
        ST_SETTLE: begin
          if (settle_ok_i) begin
            rstn_o  <= 1'b1;
            state_q <= ST_LOCK;
          end
        end
        ST_PREL: begin
          rstn_o  <= 1'b1;
          state_q <= ST_LOCK;
        end
        ST_LOCK: begin
          if (lock_i) begin
            bypass_o <= 1'b0;
            done_o   <= 1'b1;
            state_q  <= ST_IDLE;
          end else if (tmo_hit_i) begin
            timeout_o <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq #(
  parameter int M_W         = 10,
  parameter int P_W         = 6,
  parameter int S_W         = 3,
  parameter int K_W         = 16,
  parameter int SETTLE_US   = 3,
  parameter int LOCK_TMO_US = 10000,
  parameter bit LOCK_SEL_EN = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           us_tick_i,
  input  logic           req_i,
  input  logic [M_W-1:0] m_i,
  input  logic [P_W-1:0] p_i,
  input  logic [S_W-1:0] s_i,
  input  logic [K_W-1:0] k_i,
  input  logic           prep_i,
  input  logic           unprep_i,
  input  logic           lock_i,
  output logic           pll_rstn_o,
  output logic           bypass_o,
  output logic           lock_sel_o,
  output logic [M_W-1:0] m_o,
  output logic [P_W-1:0] p_o,
  output logic [S_W-1:0] s_o,
  output logic [K_W-1:0] k_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           timeout_o,
  output logic           prepared_o
);
  localparam int CNT_W = $clog2(LOCK_TMO_US + SETTLE_US + 2);

  logic mp_match, settle_ok, tmo_hit;
  logic cap, ld_full, ld_fast, tmr_clr, tmr_en;

  pll_seq_ctrl #(.LOCK_SEL_EN(LOCK_SEL_EN)) u_ctrl (
    .clk_i, .rst_ni, .req_i, .prep_i, .unprep_i, .lock_i,
    .mp_match_i (mp_match),
    .settle_ok_i(settle_ok),
    .tmo_hit_i  (tmo_hit),
    .rstn_o     (pll_rstn_o),
    .bypass_o, .lock_sel_o, .busy_o, .done_o, .timeout_o,
    .cap_o      (cap),
    .ld_full_o  (ld_full),
    .ld_fast_o  (ld_fast),
    .tmr_clr_o  (tmr_clr),
    .tmr_en_o   (tmr_en)
  );

  pll_seq_divreg #(.M_W(M_W), .P_W(P_W), .S_W(S_W), .K_W(K_W)) u_div (
    .clk_i, .rst_ni, .m_i, .p_i, .s_i, .k_i,
    .cap_i     (cap),
    .ld_full_i (ld_full),
    .ld_fast_i (ld_fast),
    .m_o, .p_o, .s_o, .k_o,
    .mp_match_o(mp_match)
  );

  pll_seq_timer #(.CNT_W(CNT_W), .SETTLE_US(SETTLE_US), .LOCK_TMO_US(LOCK_TMO_US)) u_tmr (
    .clk_i, .rst_ni,
    .tick_i     (us_tick_i),
    .clr_i      (tmr_clr),
    .en_i       (tmr_en),
    .settle_ok_o(settle_ok),
    .tmo_hit_o  (tmo_hit)
  );

  assign prepared_o = pll_rstn_o;
endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk #(
  parameter int M_W       = 10,
  parameter int P_W       = 6,
  parameter int S_W       = 3,
  parameter int SETTLE_US = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           us_tick_i,
  input logic           req_i,
  input logic           prep_i,
  input logic           unprep_i,
  input logic           lock_i,
  input logic [M_W-1:0] m_i,
  input logic [P_W-1:0] p_i,
  input logic [S_W-1:0] s_i,
  input logic [M_W-1:0] m_o,
  input logic [P_W-1:0] p_o,
  input logic [S_W-1:0] s_o,
  input logic           pll_rstn_o,
  input logic           bypass_o,
  input logic           busy_o,
  input logic           done_o,
  input logic           timeout_o
);
  logic [M_W+P_W-1:0] mp_q;
  logic [15:0]        ck_cnt;
  logic               armed;

  // ticks seen since a divider load, up to reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mp_q <= '0; ck_cnt <= '0; armed <= 1'b0;
    end else begin
      mp_q <= {m_o, p_o};
      if (busy_o && {m_o, p_o} != mp_q) begin
        armed  <= 1'b1;
        ck_cnt <= '0;
      end else if (pll_rstn_o) armed <= 1'b0;
      else if (armed && us_tick_i && ck_cnt != 16'hFFFF) ck_cnt <= ck_cnt + 1'b1;
    end
  end

  // R2
  fast_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i && !prep_i && !unprep_i && m_i == m_o && p_i == p_o)
      |=> (done_o && !busy_o && s_o == $past(s_i)));
  // R3
  div_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$stable({m_o, p_o})) |-> (!pll_rstn_o && bypass_o));
  // R4
  settle_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pll_rstn_o) && armed) |-> (ck_cnt >= 16'(SETTLE_US)));
  // R5
  bypass_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bypass_o) |-> $past(lock_i));
  // R8
  release_in_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pll_rstn_o) |-> bypass_o);
  // R6
  timeout_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (bypass_o && pll_rstn_o));
  // R9
  power_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && unprep_i) |=> (!pll_rstn_o && done_o));
  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R12
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));
endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(
  .M_W(M_W), .P_W(P_W), .S_W(S_W), .SETTLE_US(SETTLE_US)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .us_tick_i(us_tick_i), .req_i(req_i),
  .prep_i(prep_i), .unprep_i(unprep_i), .lock_i(lock_i),
  .m_i(m_i), .p_i(p_i), .s_i(s_i), .m_o(m_o), .p_o(p_o), .s_o(s_o),
  .pll_rstn_o(pll_rstn_o), .bypass_o(bypass_o), .busy_o(busy_o),
  .done_o(done_o), .timeout_o(timeout_o)
);

// File: tb/sim_pll_reprog_seq.sv
module sim_pll_reprog_seq;
  localparam int SETTLE = 3;
  localparam int TMO    = 40;
  localparam int LOCK_DLY = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic us_tick = 1'b0, req = 1'b0, prep = 1'b0, unprep = 1'b0, lock = 1'b0;
  logic [9:0]  m_in = '0;
  logic [5:0]  p_in = '0;
  logic [2:0]  s_in = '0;
  logic [15:0] k_in = '0;
  logic pll_rstn, bypass, lock_sel, busy, done, tmo_p, prepared;
  logic [9:0]  m_out;
  logic [5:0]  p_out;
  logic [2:0]  s_out;
  logic [15:0] k_out;

  always #2 clk = ~clk;

  pll_reprog_seq #(.SETTLE_US(SETTLE), .LOCK_TMO_US(TMO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .us_tick_i(us_tick), .req_i(req),
    .m_i(m_in), .p_i(p_in), .s_i(s_in), .k_i(k_in),
    .prep_i(prep), .unprep_i(unprep), .lock_i(lock),
    .pll_rstn_o(pll_rstn), .bypass_o(bypass), .lock_sel_o(lock_sel),
    .m_o(m_out), .p_o(p_out), .s_o(s_out), .k_o(k_out),
    .busy_o(busy), .done_o(done), .timeout_o(tmo_p), .prepared_o(prepared)
  );

  typedef struct packed {
    logic        tmo;
    logic        rstn;
    logic        byp;
    logic [9:0]  m;
    logic [5:0]  p;
    logic [2:0]  s;
    logic [15:0] k;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int n_chk = 0, n_fail = 0;
  int tick_total = 0;
  int tdiv = 0;
  int lock_cnt = 0;
  bit lock_en = 1'b1;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  task automatic push(string tag, logic t, logic r, logic b,
                      logic [9:0] m, logic [5:0] p, logic [2:0] s, logic [15:0] k);
    exp_t e;
    e = '{tmo: t, rstn: r, byp: b, m: m, p: p, s: s, k: k};
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // microsecond tick every fourth clock
  always @(negedge clk) begin
    tdiv    = (tdiv == 3) ? 0 : tdiv + 1;
    us_tick = (tdiv == 0);
  end
  always @(posedge clk) if (us_tick) tick_total++;

  // behavioral lock: asserts LOCK_DLY cycles after reset release
  always @(negedge clk) begin
    if (!pll_rstn) lock_cnt = 0;
    else if (lock_en && lock_cnt < LOCK_DLY) lock_cnt++;
    lock = pll_rstn && lock_en && (lock_cnt >= LOCK_DLY);
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (done || tmo_p)) begin
      exp_t  a;
      string t;
      chk("R12 exclusive pulse", {63'd0, done & tmo_p}, 64'd0);
      a = '{tmo: tmo_p, rstn: pll_rstn, byp: bypass, m: m_out, p: p_out, s: s_out, k: k_out};
      if (exp_q.size() == 0) chk("R12 unexpected pulse", 64'(a), 64'd0);
      else begin
        t = tag_q.pop_front();
        chk(t, 64'(a), 64'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  task automatic do_prepare(string tag, bit expect_tmo);
    int t0, t1;
    if (expect_tmo) push(tag, 1, 1, 1, m_out, p_out, s_out, k_out);
    else            push(tag, 0, 1, 0, m_out, p_out, s_out, k_out);
    @(negedge clk); prep = 1'b1;
    @(negedge clk); prep = 1'b0;
    chk("R8 bypass set first", {62'd0, bypass, pll_rstn}, 64'b10);
    chk("R11 busy during power-up", {63'd0, busy}, 64'd1);
    @(negedge clk);
    chk("R8 reset released next", {62'd0, bypass, pll_rstn}, 64'b11);
    chk("R10 prepared high", {63'd0, prepared}, 64'd1);
    t0 = tick_total;
    if (expect_tmo) begin
      while (!tmo_p) @(negedge clk);
      t1 = tick_total;
      chk("R6 timeout span", {63'd0, (t1 - t0 >= TMO) && (t1 - t0 <= TMO + 1)}, 64'd1);
    end
    wait_idle();
  endtask

  task automatic full_change(logic [9:0] m, logic [5:0] p, logic [2:0] s, logic [15:0] k,
                             bit inject);
    int t0, t1;
    logic [9:0] m_old;
    m_old = m_out;
    push("R5 full change done", 0, 1, 0, m, p, s, k);
    @(negedge clk); req = 1'b1; m_in = m; p_in = p; s_in = s; k_in = k;
    @(negedge clk); req = 1'b0;
    chk("R3 step1 lock_sel", {61'd0, lock_sel, pll_rstn, bypass}, 64'b110);
    @(negedge clk);
    chk("R3 step2 reset", {62'd0, pll_rstn, bypass}, 64'b00);
    chk("R10 prepared low", {63'd0, prepared}, 64'd0);
    if (inject) begin
      req = 1'b1; m_in = 10'd7; unprep = 1'b1; prep = 1'b1;
    end
    @(negedge clk);
    req = 1'b0; unprep = 1'b0; prep = 1'b0;
    chk("R3 step3 bypass", {54'd0, bypass, m_out}, {54'd0, 1'b1, m_old});
    @(negedge clk);
    chk("R3 step4 dividers", {29'd0, m_out, p_out, s_out, k_out}, {29'd0, m, p, s, k});
    t0 = tick_total;
    while (!pll_rstn) @(negedge clk);
    t1 = tick_total;
    chk("R4 settle ticks", {63'd0, (t1 - t0) > SETTLE}, 64'd1);
    wait_idle();
    if (inject)
      chk("R11 ignored while busy", {53'd0, pll_rstn, m_out}, {53'd0, 1'b1, m});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset controls", {57'd0, pll_rstn, bypass, lock_sel, busy, done, tmo_p, prepared},
        64'd0);
    chk("R1 reset dividers", {29'd0, m_out, p_out, s_out, k_out}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // power-up from power-down
    do_prepare("R8 power-up done", 1'b0);

    // power-up while already up
    push("R7 no-op power-up", 0, 1, 0, m_out, p_out, s_out, k_out);
    @(negedge clk); prep = 1'b1;
    @(negedge clk); prep = 1'b0;
    chk("R7 no busy", {62'd0, busy, bypass}, 64'd0);

    // full relock
    full_change(10'd100, 6'd3, 3'd1, 16'd0, 1'b0);
    chk("R3 lock_sel held", {63'd0, lock_sel}, 64'd1);

    // same M/P: only S and K
    push("R2 fast path done", 0, 1, 0, 10'd100, 6'd3, 3'd2, 16'd16384);
    @(negedge clk); req = 1'b1; s_in = 3'd2; k_in = 16'd16384;
    @(negedge clk); req = 1'b0;
    chk("R2 fast path state", {60'd0, busy, bypass, pll_rstn, s_out == 3'd2}, 64'b0011);

    // relock with requests thrown at it while busy
    full_change(10'd200, 6'd3, 3'd0, 16'd5, 1'b1);

    // all three requests at once: power-down wins
    push("R9 power-down done", 0, 0, 0, 10'd200, 6'd3, 3'd0, 16'd5);
    @(negedge clk); unprep = 1'b1; prep = 1'b1; req = 1'b1; m_in = 10'd9;
    @(negedge clk); unprep = 1'b0; prep = 1'b0; req = 1'b0;
    chk("R11 priority power-down", {61'd0, pll_rstn, busy, bypass}, 64'd0);
    chk("R10 prepared follows", {63'd0, prepared}, 64'd0);

    // power-up with no lock
    lock_en = 1'b0;
    do_prepare("R6 timeout pulse", 1'b1);
    chk("R6 stays in bypass", {62'd0, bypass, pll_rstn}, 64'b11);

    repeat (10) @(negedge clk);
    chk("R12 all pulses seen", 64'(exp_q.size()), 64'd0);
    summary();
  end
endmodule